// File: doc/BRIEF.md
# Edge-Latched Interrupt Line Controller

The controller watches 40 interrupt lines and turns activity on them into interrupt outputs. It has two kinds of line. A configurable line keeps a pending flag. The flag is set by a selected edge on the line's synchronized hardware input, or by a software trigger. It stays set until software writes a one to clear it. A direct line keeps no state: its output follows its synchronized input whenever the line is unmasked.

Software reaches the block through a small 32-bit register port with a word-aligned byte offset. There are two banks of six registers each. The first bank covers lines 0 to 31, and the second bank covers lines 32 to 39 in its bits 7:0. Within each bank, the registers sit at these offsets from the bank base:

| Offset | Register |
|---|---|
| +0x00 | line mask |
| +0x04 | event mask (storage only) |
| +0x08 | rising-edge select |
| +0x0C | falling-edge select |
| +0x10 | software trigger |
| +0x14 | pending |

The first bank base is 0x00 and the second is 0x20. Reads return data one cycle after the request. Only lines 0 to 15 take hardware edges.

Top module: `ext_line_ctrl`

## Requirements
- R1: After reset, the bank-1 line mask reads 0xFF820000 and the bank-2 line mask reads 0x00000087. Every other register reads zero, and with all inputs low every `irq_out` bit is 0.
- R2: Read data appears on `rdata` in the cycle after `rd_en`. The line mask and event mask of bank 1 keep all 32 bits written. In bank 2, these two registers keep only bits 7:0.
- R3: The edge-select registers drop writes to direct lines (bank 1 bits 0xFF820000, bank 2 bits 0x87) and to bank-2 bits 31:8. All-ones reads back 0x007DFFFF in bank 1 and 0x00000078 in bank 2.
- R4: A configurable line below 16 sets its pending bit on a rising input edge when its mask and rising-select bits are 1. It does the same on a falling edge when its mask and falling-select bits are 1. An edge of the unselected polarity does nothing.
- R5: An edge on a masked line never sets its pending bit. Unmasking the line afterwards does not pend the missed edge.
- R6: A software-trigger write stores the filtered value. Each bit that goes from 0 to 1 sets its pending bit if the line is unmasked and not already pending. This works in both banks.
- R7: A trigger bit that was stored while the line was masked does not pend when the mask is set later. Rewriting a trigger bit that is already 1 does not pend.
- R8: Writing 1 to a pending bit clears that bit and the matching trigger bit. Writing 0 has no effect. Trigger and pending writes to direct or reserved bits are dropped.
- R9: The `irq_out` bit of a configurable line is high exactly while its pending bit is set.
- R10: The `irq_out` bit of a direct line equals its synchronized input ANDed with its mask bit. Direct lines never set a pending bit.
- R11: An access at a misaligned offset, or at an offset outside the twelve registers, raises `bus_err` in the next cycle. Such a read returns zero, and such a write changes no state.
- R12: If a hardware edge and a clearing write hit the same pending bit in the same cycle, the bit stays set.
- R13: Configurable lines at index 16 and above ignore `src_in` and can be pended only by software.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| bus_err | output | 1 | Pulses the cycle after an access to an unmapped or misaligned offset |
| src_in | input | 40 | Asynchronous line inputs |
| irq_out | output | 40 | Per-line interrupt outputs |

## Verification
A hardware edge reaching a pending bit can coincide with a software write that clears the same bit. The bench provokes this on line 1. It first pends the line through a software trigger. It then raises the line's input and counts two synchronizer edges, so that the pending-clear write is sampled on the same clock edge as the detected rising edge. The bench judges the outcome by reading the pending register afterwards and expecting the bit still set. A plain clear issued later must then drop the bit.

// File: rtl/elc_pkg.sv
package elc_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned LINES_DEF = 40;
  localparam logic [39:0] DIRECT_DEF = 40'h87_FF82_0000;

  typedef enum logic [2:0] {
    SEL_MASK   = 3'd0,
    SEL_EVMASK = 3'd1,
    SEL_RISE   = 3'd2,
    SEL_FALL   = 3'd3,
    SEL_SWTRIG = 3'd4,
    SEL_PEND   = 3'd5
  } reg_sel_e;

  localparam logic [2:0] SEL_LAST = 3'd5;
endpackage

// File: rtl/elc_sync.sv
module elc_sync #(
  parameter int unsigned NUM_LINES   = 40,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] src_in,
  output logic [NUM_LINES-1:0] cur_o,
  output logic [NUM_LINES-1:0] prev_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [NUM_LINES-1:0] stg_q [SYNC_STAGES];
  logic [NUM_LINES-1:0] stg_n [SYNC_STAGES];
  logic [NUM_LINES-1:0] prev_q, prev_n;

  // Stage inputs: the first stage takes the raw input, each later stage the one before it.
  always_comb begin
    stg_n[0] = src_in;
    for (int k = 1; k < SYNC_STAGES; k++) stg_n[k] = stg_q[k-1];
    prev_n = stg_q[LAST];
  end

  for (genvar k = 0; k < SYNC_STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[k] <= '0;
      else        stg_q[k] <= stg_n[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_n;
  end

  assign cur_o  = stg_q[LAST];
  assign prev_o = prev_q;
endmodule

// File: rtl/elc_edge.sv
module elc_edge #(
  parameter int unsigned          NUM_LINES   = 40,
  parameter int unsigned          GPIO_LINES  = 16,
  parameter logic [NUM_LINES-1:0] DIRECT_MASK = '0
) (
  input  logic [NUM_LINES-1:0] cur_i,
  input  logic [NUM_LINES-1:0] prev_i,
  input  logic [NUM_LINES-1:0] imr_i,
  input  logic [NUM_LINES-1:0] rsel_i,
  input  logic [NUM_LINES-1:0] fsel_i,
  output logic [NUM_LINES-1:0] hw_set_o
);
  // Only configurable lines below GPIO_LINES have a hardware source.
  localparam logic [NUM_LINES-1:0] GPIO_M = {NUM_LINES{1'b1}} >> (NUM_LINES - GPIO_LINES);
  localparam logic [NUM_LINES-1:0] HW_M   = GPIO_M & ~DIRECT_MASK;

  logic [NUM_LINES-1:0] rise, fall;

  always_comb begin
    rise     = cur_i & ~prev_i;
    fall     = ~cur_i & prev_i;
    hw_set_o = HW_M & imr_i & ((rsel_i & rise) | (fsel_i & fall));
  end
endmodule

// File: rtl/elc_regs.sv
module elc_regs
  import elc_pkg::*;
#(
  parameter int unsigned          NUM_LINES   = 40,
  parameter int unsigned          ADDR_W      = 8,
  parameter logic [NUM_LINES-1:0] DIRECT_MASK = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [WORD_W-1:0]    wdata,
  input  logic [NUM_LINES-1:0] hw_set,
  output logic [WORD_W-1:0]    rdata,
  output logic                 bus_err,
  output logic [NUM_LINES-1:0] imr_q,
  output logic [NUM_LINES-1:0] rsel_q,
  output logic [NUM_LINES-1:0] fsel_q,
  output logic [NUM_LINES-1:0] swt_q,
  output logic [NUM_LINES-1:0] pend_q
);
  localparam int unsigned          BANKS  = (NUM_LINES + WORD_W - 1) / WORD_W;
  localparam int unsigned          BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1;
  localparam int unsigned          HI_W   = ADDR_W - 5;
  localparam logic [NUM_LINES-1:0] CFG_M  = ~DIRECT_MASK;

  logic [HI_W-1:0]      hi_f;
  logic [2:0]           reg_f;
  logic [BANK_W-1:0]    bank_sel;
  logic                 mapped, we;
  reg_sel_e             sel;
  logic [NUM_LINES-1:0] wvec, lane, rvec, clr, sw_set;
  logic [NUM_LINES-1:0] imr_n, emr_n, rsel_n, fsel_n, swt_n, pend_n;
  logic [NUM_LINES-1:0] emr_q;
  logic [WORD_W-1:0]    rd_n, rdata_q;
  logic                 err_n, err_q;

  // Address decode
  always_comb begin
    hi_f     = addr[ADDR_W-1:5];
    reg_f    = addr[4:2];
    bank_sel = addr[5 +: BANK_W];
    mapped   = (addr[1:0] == 2'b00) && (reg_f <= SEL_LAST) && (hi_f < HI_W'(BANKS));
    we       = wr_en && mapped;
    sel      = reg_sel_e'(reg_f);
    err_n    = (wr_en || rd_en) && !mapped;
  end

  // Spread the word onto the line vector of the addressed bank
  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      lane[i] = ((i / WORD_W) == int'(bank_sel));
      wvec[i] = wdata[i % WORD_W];
    end
  end

  // Next-state logic
  always_comb begin
    imr_n  = imr_q;
    emr_n  = emr_q;
    rsel_n = rsel_q;
    fsel_n = fsel_q;
    swt_n  = swt_q;
    clr    = '0;
    sw_set = '0;
    if (we) begin
      case (sel)
        SEL_MASK:   imr_n  = (imr_q & ~lane) | (wvec & lane);
        SEL_EVMASK: emr_n  = (emr_q & ~lane) | (wvec & lane);
        SEL_RISE:   rsel_n = (rsel_q & ~lane) | (wvec & lane & CFG_M);
        SEL_FALL:   fsel_n = (fsel_q & ~lane) | (wvec & lane & CFG_M);
        SEL_SWTRIG: begin
          swt_n  = (swt_q & ~lane) | (wvec & lane & CFG_M);
          sw_set = wvec & lane & CFG_M & ~swt_q & imr_q & ~pend_q;
        end
        SEL_PEND:   clr = wvec & lane & CFG_M;
        default:    ;
      endcase
    end
    swt_n  = swt_n & ~clr;
    // A fresh hardware edge overrides a clear in the same cycle.
    pend_n = (pend_q & ~clr) | sw_set | (hw_set & CFG_M);
  end

  // Read mux
  always_comb begin
    case (sel)
      SEL_MASK:   rvec = imr_q;
      SEL_EVMASK: rvec = emr_q;
      SEL_RISE:   rvec = rsel_q;
      SEL_FALL:   rvec = fsel_q;
      SEL_SWTRIG: rvec = swt_q;
      SEL_PEND:   rvec = pend_q;
      default:    rvec = '0;
    endcase
    rd_n = '0;
    if (mapped) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if ((i / WORD_W) == int'(bank_sel)) rd_n[i % WORD_W] = rvec[i];
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr_q   <= DIRECT_MASK;
      emr_q   <= '0;
      rsel_q  <= '0;
      fsel_q  <= '0;
      swt_q   <= '0;
      pend_q  <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (we) begin
        imr_q  <= imr_n;
        emr_q  <= emr_n;
        rsel_q <= rsel_n;
        fsel_q <= fsel_n;
        swt_q  <= swt_n;
      end
      pend_q <= pend_n;
      if (rd_en) rdata_q <= rd_n;
      err_q <= err_n;
    end
  end

  assign rdata   = rdata_q;
  assign bus_err = err_q;
endmodule

// File: rtl/ext_line_ctrl.sv
module ext_line_ctrl
  import elc_pkg::*;
#(
  parameter int unsigned          NUM_LINES   = LINES_DEF,
  parameter int unsigned          GPIO_LINES  = 16,
  parameter int unsigned          SYNC_STAGES = 2,
  parameter int unsigned          ADDR_W      = 8,
  parameter logic [NUM_LINES-1:0] DIRECT_MASK = DIRECT_DEF[NUM_LINES-1:0]
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [WORD_W-1:0]    wdata,
  output logic [WORD_W-1:0]    rdata,
  output logic                 bus_err,
  input  logic [NUM_LINES-1:0] src_in,
  output logic [NUM_LINES-1:0] irq_out
);
  logic [NUM_LINES-1:0] cur_s, prev_s, hw_set;
  logic [NUM_LINES-1:0] imr_q, rsel_q, fsel_q, swt_q, pend_q;

  elc_sync #(.NUM_LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .cur_o(cur_s), .prev_o(prev_s)
  );

  elc_edge #(.NUM_LINES(NUM_LINES), .GPIO_LINES(GPIO_LINES), .DIRECT_MASK(DIRECT_MASK)) u_edge (
    .cur_i(cur_s), .prev_i(prev_s), .imr_i(imr_q), .rsel_i(rsel_q), .fsel_i(fsel_q),
    .hw_set_o(hw_set)
  );

  elc_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DIRECT_MASK(DIRECT_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .hw_set(hw_set), .rdata(rdata), .bus_err(bus_err),
    .imr_q(imr_q), .rsel_q(rsel_q), .fsel_q(fsel_q), .swt_q(swt_q), .pend_q(pend_q)
  );

  // Configurable lines report their pending flag; direct lines pass through when unmasked.
  assign irq_out = (pend_q & ~DIRECT_MASK) | (cur_s & DIRECT_MASK & imr_q);
endmodule

// File: rtl/elc_checker.sv
module elc_checker #(
  parameter int unsigned          NUM_LINES   = 40,
  parameter int unsigned          ADDR_W      = 8,
  parameter logic [NUM_LINES-1:0] DIRECT_MASK = '0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [31:0]          rdata,
  input logic                 bus_err,
  input logic [NUM_LINES-1:0] irq_out,
  input logic [NUM_LINES-1:0] imr_q,
  input logic [NUM_LINES-1:0] rsel_q,
  input logic [NUM_LINES-1:0] fsel_q,
  input logic [NUM_LINES-1:0] swt_q,
  input logic [NUM_LINES-1:0] pend_q
);
  localparam int unsigned          BANKS = (NUM_LINES + 31) / 32;
  localparam int unsigned          HI_W  = ADDR_W - 5;
  localparam logic [NUM_LINES-1:0] CFG_M = ~DIRECT_MASK;

  logic legal;
  assign legal = (addr[1:0] == 2'b00) && (addr[4:2] <= 3'd5) &&
                 (addr[ADDR_W-1:5] < HI_W'(BANKS));

  assert_err_unmapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) && !legal |=> bus_err);

  assert_no_err_mapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) && legal |=> !bus_err);

  assert_rd_zero_unmapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !legal |=> (rdata == 32'h0));

  assert_direct_bits_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((rsel_q | fsel_q | swt_q | pend_q) & DIRECT_MASK) == '0);

  assert_direct_masked_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & DIRECT_MASK & ~imr_q) == '0);

  assert_no_rise_when_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_out & ~$past(irq_out) & CFG_M & ~$past(imr_q)) == '0));
endmodule

bind ext_line_ctrl elc_checker #(
  .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .DIRECT_MASK(DIRECT_MASK)
) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .bus_err(bus_err), .irq_out(irq_out),
  .imr_q(imr_q), .rsel_q(rsel_q), .fsel_q(fsel_q), .swt_q(swt_q), .pend_q(pend_q)
);

// File: tb/ext_line_ctrl_tb_top.sv
module ext_line_ctrl_tb_top;
  localparam logic [7:0] O_MASK1 = 8'h00, O_EV1 = 8'h04, O_RISE1 = 8'h08, O_FALL1 = 8'h0C,
                         O_SWT1  = 8'h10, O_PEND1 = 8'h14;
  localparam logic [7:0] O_MASK2 = 8'h20, O_EV2 = 8'h24, O_FALL2 = 8'h2C,
                         O_SWT2  = 8'h30, O_PEND2 = 8'h34;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic        bus_err;
  logic [39:0] src_in, irq_out;

  int n_chk  = 0;
  int n_fail = 0;

  logic [32:0] exp_q [$];
  string       tag_q [$];
  logic        rd_seen;

  always #5 clk = ~clk;

  ext_line_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .bus_err(bus_err), .src_in(src_in), .irq_out(irq_out)
  );

  // Monitor: every accepted read produces one result the next cycle
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_seen <= 1'b0;
    else        rd_seen <= rd_en;
  end

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [32:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if ({bus_err, rdata} !== e) begin
        n_fail++;
        $display("FAIL %s: read err/data %0b/%08h expected %0b/%08h", t, bus_err, rdata, e[32], e[31:0]);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input logic eerr, input string t);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back({eerr, e});
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic chk_irq(input logic [39:0] e, input string t);
    n_chk++;
    if (irq_out !== e) begin
      n_fail++;
      $display("FAIL %s: irq_out %010h expected %010h", t, irq_out, e);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; src_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_irq(40'h0, "R1 irq after reset");
    rd(O_MASK1, 32'hFF82_0000, 1'b0, "R1 mask1 reset");
    rd(O_MASK2, 32'h0000_0087, 1'b0, "R1 mask2 reset");
    rd(O_RISE1, 32'h0, 1'b0, "R1 rise1 reset");
    rd(O_PEND1, 32'h0, 1'b0, "R1 pend1 reset");
    rd(O_SWT2,  32'h0, 1'b0, "R1 swt2 reset");

    // R2 mask and event-mask storage
    wr(O_MASK1, 32'hFFFF_FFFF); rd(O_MASK1, 32'hFFFF_FFFF, 1'b0, "R2 mask1 ones");
    wr(O_MASK2, 32'hFFFF_FFFF); rd(O_MASK2, 32'h0000_00FF, 1'b0, "R2 mask2 low byte");
    wr(O_EV2,   32'hFFFF_FFFF); rd(O_EV2,   32'h0000_00FF, 1'b0, "R2 evmask2 low byte");
    wr(O_EV1,   32'h1234_5678); rd(O_EV1,   32'h1234_5678, 1'b0, "R2 evmask1 pattern");
    wr(O_MASK1, 32'h0); wr(O_MASK2, 32'h0);

    // R3 edge-select filtering
    wr(O_RISE1, 32'hFFFF_FFFF); rd(O_RISE1, 32'h007D_FFFF, 1'b0, "R3 rise1 ones");
    wr(O_FALL2, 32'hFFFF_FFFF); rd(O_FALL2, 32'h0000_0078, 1'b0, "R3 fall2 ones");
    wr(O_FALL1, 32'hFF82_0000); rd(O_FALL1, 32'h0, 1'b0, "R3 fall1 direct bits");
    wr(O_RISE1, 32'h0); wr(O_FALL2, 32'h0);

    // R4 edge latching
    wr(O_MASK1, 32'h3); wr(O_RISE1, 32'h1); wr(O_FALL1, 32'h2);
    src_in[0] = 1'b1; settle();
    rd(O_PEND1, 32'h1, 1'b0, "R4 rising edge line0");
    src_in[1] = 1'b1; settle();
    rd(O_PEND1, 32'h1, 1'b0, "R4 unselected rise line1");
    src_in[1] = 1'b0; settle();
    rd(O_PEND1, 32'h3, 1'b0, "R4 falling edge line1");
    chk_irq(40'h3, "R9 irq follows pending");
    src_in[0] = 1'b0; settle();
    rd(O_PEND1, 32'h3, 1'b0, "R4 unselected fall line0");

    // R8 clearing
    wr(O_PEND1, 32'h0); rd(O_PEND1, 32'h3, 1'b0, "R8 zero write no effect");
    wr(O_PEND1, 32'h1); rd(O_PEND1, 32'h2, 1'b0, "R8 clear line0");
    chk_irq(40'h2, "R9 irq drops on clear");
    wr(O_PEND1, 32'h2); rd(O_PEND1, 32'h0, 1'b0, "R8 clear line1");

    // R5 masked edge
    wr(O_MASK1, 32'h0); wr(O_RISE1, 32'h4);
    src_in[2] = 1'b1; settle();
    rd(O_PEND1, 32'h0, 1'b0, "R5 masked edge");
    wr(O_MASK1, 32'h4);
    rd(O_PEND1, 32'h0, 1'b0, "R5 no retro pend");
    chk_irq(40'h0, "R5 irq stays low");
    src_in[2] = 1'b0; settle();
    wr(O_RISE1, 32'h0); wr(O_FALL1, 32'h0);

    // R6 software trigger, bank 1
    wr(O_MASK1, 32'h1); wr(O_SWT1, 32'h0); wr(O_SWT1, 32'h1);
    rd(O_SWT1, 32'h1, 1'b0, "R6 trigger stored");
    rd(O_PEND1, 32'h1, 1'b0, "R6 trigger pends");
    chk_irq(40'h1, "R9 irq from trigger");
    wr(O_PEND1, 32'h0); rd(O_PEND1, 32'h1, 1'b0, "R8 zero write keeps pend");
    wr(O_PEND1, 32'h1);
    rd(O_PEND1, 32'h0, 1'b0, "R8 clear pend");
    rd(O_SWT1, 32'h0, 1'b0, "R8 clear also trigger");
    chk_irq(40'h0, "R9 irq low after clear");

    // R7 trigger while masked / no rewrite pend
    wr(O_MASK1, 32'h0); wr(O_SWT1, 32'h1);
    rd(O_PEND1, 32'h0, 1'b0, "R7 masked trigger");
    wr(O_MASK1, 32'h1);
    rd(O_PEND1, 32'h0, 1'b0, "R7 no pend on unmask");
    wr(O_SWT1, 32'h1);
    rd(O_PEND1, 32'h0, 1'b0, "R7 rewrite of 1 no pend");
    chk_irq(40'h0, "R7 irq low");
    wr(O_SWT1, 32'h0);

    // R8 direct and reserved bits dropped
    wr(O_SWT1, 32'hFF82_0000); rd(O_SWT1, 32'h0, 1'b0, "R8 swt1 direct bits");
    wr(O_SWT2, 32'hFFFF_FF87); rd(O_SWT2, 32'h0, 1'b0, "R8 swt2 direct+reserved");
    wr(O_PEND2, 32'hFFFF_FFFF); rd(O_PEND2, 32'h0, 1'b0, "R8 pend2 ones");

    // R10 direct lines
    wr(O_MASK1, 32'h0002_0000);
    src_in[17] = 1'b1; settle();
    chk_irq(40'h00_0002_0000, "R10 direct line17 passes");
    rd(O_PEND1, 32'h0, 1'b0, "R10 direct no pend");
    wr(O_MASK1, 32'h0);
    chk_irq(40'h0, "R10 direct line17 masked");
    wr(O_MASK2, 32'h1);
    src_in[32] = 1'b1; settle();
    chk_irq(40'h01_0000_0000, "R10 direct line32 passes");
    rd(O_PEND2, 32'h0, 1'b0, "R10 bank2 direct no pend");
    src_in[17] = 1'b0; src_in[32] = 1'b0; wr(O_MASK2, 32'h0); settle();
    chk_irq(40'h0, "R10 direct low");

    // R11 unmapped and misaligned
    rd(8'h18, 32'h0, 1'b1, "R11 unmapped read");
    wr(8'h18, 32'hFFFF_FFFF);
    n_chk++;
    if (bus_err !== 1'b1) begin
      n_fail++;
      $display("FAIL R11 write error flag: %0b expected 1", bus_err);
    end
    rd(O_MASK1, 32'h0, 1'b0, "R11 no state change");
    rd(8'h01, 32'h0, 1'b1, "R11 misaligned read");
    rd(8'h40, 32'h0, 1'b1, "R11 beyond banks");

    // R12 edge and clear in one cycle
    wr(O_MASK1, 32'h2); wr(O_RISE1, 32'h2); wr(O_FALL1, 32'h0);
    wr(O_SWT1, 32'h2); wr(O_SWT1, 32'h0);
    rd(O_PEND1, 32'h2, 1'b0, "R12 precondition pending");
    @(negedge clk);
    src_in[1] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; addr = O_PEND1; wdata = 32'h2;
    @(negedge clk);
    wr_en = 1'b0;
    rd(O_PEND1, 32'h2, 1'b0, "R12 edge wins over clear");
    src_in[1] = 1'b0; settle();
    wr(O_PEND1, 32'h2); rd(O_PEND1, 32'h0, 1'b0, "R12 later clear");

    // R13 upper configurable lines ignore inputs
    wr(O_MASK1, 32'h0004_0000); wr(O_RISE1, 32'h0004_0000);
    src_in[18] = 1'b1; settle();
    rd(O_PEND1, 32'h0, 1'b0, "R13 line18 ignores input");
    chk_irq(40'h0, "R13 irq low");
    wr(O_SWT1, 32'h0004_0000);
    rd(O_PEND1, 32'h0004_0000, 1'b0, "R13 line18 software pend");
    chk_irq(40'h00_0004_0000, "R9 irq line18");
    wr(O_PEND1, 32'h0004_0000); rd(O_PEND1, 32'h0, 1'b0, "R8 clear line18");
    src_in[18] = 1'b0;

    // R6 software trigger, bank 2
    wr(O_MASK2, 32'h8); wr(O_SWT2, 32'h0); wr(O_SWT2, 32'h8);
    rd(O_SWT2, 32'h8, 1'b0, "R6 bank2 trigger stored");
    rd(O_PEND2, 32'h8, 1'b0, "R6 bank2 trigger pends");
    chk_irq(40'h08_0000_0000, "R9 irq line35");
    wr(O_PEND2, 32'h8);
    rd(O_PEND2, 32'h0, 1'b0, "R8 bank2 clear");
    rd(O_SWT2, 32'h0, 1'b0, "R8 bank2 trigger cleared");

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule